// File: doc/BRIEF.md
# PCI Address Translation Window Unit

This block holds two groups of programmable address windows between a local CPU address space and a PCI bus address space. The outbound group turns CPU addresses into PCI bus addresses. The inbound group turns addresses from PCI bus-master DMA into local memory addresses. Software sets each window through a 32-bit register port. A window has a base, a translation target, a power-of-two size and an enable bit. A window's base and its target need not be equal, so a CPU window high in a 64-bit space can point at a PCI range below 4 GB.

Each direction has its own combinational lookup port. The port takes a 64-bit address and returns three results: a hit flag, the translated address and the index of the matching window. A register write takes effect at the clock edge that captures it. The next lookup therefore uses the new mapping.

Top module: `pci_xlat_unit`

## Requirements
- R1: After reset, every stored register reads zero and every window is disabled, so both lookup ports miss.
- R2: Register address bit 8 selects the group: 0 is outbound, 1 is inbound. For the outbound group, bits 7:5 give the window index. For the inbound group, bit 7 must be 0 and bits 6:5 minus one give the index. Bits 4:0 select the register within the window. For both groups, offset 0x00 is the translation page, 0x08 is the base page and 0x10 is the attribute. The high-page register sits at offset 0x04 for outbound windows and at offset 0x0C for inbound windows. A read returns the full 32-bit stored value.
- R3: Any other address reads zero, and a write to it changes no register and no lookup result. This covers bad offsets, out-of-range window indexes, inbound index field 0 and inbound addresses with bit 7 set.
- R4: A window whose attribute bit 31 is clear never matches.
- R5: Attribute bits 5:0 hold a size code n. The window matches an address A when base <= A < base + 2^(n+1), compared without wrap. Code 63 covers 2^64 bytes.
- R6: For outbound windows, the byte base is the base page shifted left by 12. The byte target is {high page bits 19:0, translation page} shifted left by 12. On a hit, the result is target + (A - base), modulo 2^64.
- R7: For inbound windows, the byte base is {high page bits 19:0, base page} shifted left by 12. The byte target is the translation page shifted left by 12. The result uses the same offset rule as R6.
- R8: When several windows of a group match, the lowest index wins. Its index appears on the index output.
- R9: On a miss, the hit flag, the translated address and the index are all zero.
- R10: A write to any register of a window changes the lookup result from the next clock cycle on. A window that is disabled or shrunk stops matching its old range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ob_addr | input | 64 | CPU address to translate outbound |
| ob_hit | output | 1 | Outbound lookup matched |
| ob_xaddr | output | 64 | PCI bus address result |
| ob_idx | output | 3 | Index of the matching outbound window |
| ib_addr | input | 64 | PCI DMA address to translate inbound |
| ib_hit | output | 1 | Inbound lookup matched |
| ib_xaddr | output | 64 | Local address result |
| ib_idx | output | 2 | Index of the matching inbound window |

## Verification
The assertions assume that at most one register write happens per cycle. They also assume that reg_addr and reg_wdata hold steady across the capturing edge, because the disable checks compare the write seen one cycle back with the lookup result now. The bench drives every input on the falling edge and issues one write at a time. During the internal reset window it only waits, so no write is captured while the registers are held clear. Lookup addresses and register values run over the full 64-bit and 32-bit ranges, including addresses that hit no window.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int XA_W  = 64;
  localparam int PG_SH = 12;
  localparam int SZC_W = 6;
  localparam int EN_BIT = 31;

  localparam logic [4:0] OFS_XLAT   = 5'h00;
  localparam logic [4:0] OFS_OB_EXT = 5'h04;
  localparam logic [4:0] OFS_BASE   = 5'h08;
  localparam logic [4:0] OFS_IB_EXT = 5'h0C;
  localparam logic [4:0] OFS_ATTR   = 5'h10;

  typedef enum logic [1:0] {
    F_XLAT = 2'd0,
    F_EXT  = 2'd1,
    F_BASE = 2'd2,
    F_ATTR = 2'd3
  } fld_e;

  typedef struct packed {
    logic             en;
    logic [SZC_W-1:0] szc;
    logic [XA_W-1:0]  base;
    logic [XA_W-1:0]  xlat;
  } win_cfg_t;

  function automatic logic [XA_W-1:0] page_to_byte(input logic [19:0] hi,
                                                   input logic [31:0] lo);
    return {hi, lo, {PG_SH{1'b0}}};
  endfunction
endpackage

// File: rtl/pxu_bank.sv
module pxu_bank
  import pxu_pkg::*;
#(
  parameter int NWIN    = 5,
  parameter bit INBOUND = 1'b0,
  localparam int IW     = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [8:0]            addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output win_cfg_t [NWIN-1:0]   cfg
);
  logic [31:0] regs_q [NWIN][4];
  logic [31:0] regs_d [NWIN][4];
  logic [2:0]  widx;
  logic        in_bank, fld_ok, win_ok, upd;
  fld_e        fld;
  logic [IW-1:0] widx_c;

  // address decode
  always_comb begin
    if (INBOUND) begin
      in_bank = addr[8] && !addr[7] && (addr[6:5] != 2'b00);
      widx    = addr[7:5] - 3'd1;
    end else begin
      in_bank = !addr[8];
      widx    = addr[7:5];
    end
    fld_ok = 1'b1;
    fld    = F_XLAT;
    if (addr[4:0] == OFS_XLAT)      fld = F_XLAT;
    else if (addr[4:0] == OFS_BASE) fld = F_BASE;
    else if (addr[4:0] == OFS_ATTR) fld = F_ATTR;
    else if (addr[4:0] == (INBOUND ? OFS_IB_EXT : OFS_OB_EXT)) fld = F_EXT;
    else fld_ok = 1'b0;
    win_ok = in_bank && fld_ok && ({1'b0, widx} < 4'(NWIN));
    widx_c = win_ok ? widx[IW-1:0] : '0;
    upd    = wr_en && win_ok;
  end

  // next state
  always_comb begin
    regs_d = regs_q;
    if (upd) regs_d[widx_c][fld] = wdata;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWIN; w++)
        for (int f = 0; f < 4; f++)
          regs_q[w][f] <= '0;
    end else if (upd) begin
      regs_q <= regs_d;
    end
  end

  assign rdata = win_ok ? regs_q[widx_c][fld] : 32'h0;

  for (genvar w = 0; w < NWIN; w++) begin : g_cfg
    if (INBOUND) begin : g_ib
      assign cfg[w] = '{en:   regs_q[w][F_ATTR][EN_BIT],
                        szc:  regs_q[w][F_ATTR][SZC_W-1:0],
                        base: page_to_byte(regs_q[w][F_EXT][19:0], regs_q[w][F_BASE]),
                        xlat: page_to_byte(20'h0, regs_q[w][F_XLAT])};
    end else begin : g_ob
      assign cfg[w] = '{en:   regs_q[w][F_ATTR][EN_BIT],
                        szc:  regs_q[w][F_ATTR][SZC_W-1:0],
                        base: page_to_byte(20'h0, regs_q[w][F_BASE]),
                        xlat: page_to_byte(regs_q[w][F_EXT][19:0], regs_q[w][F_XLAT])};
    end
  end
endmodule

// File: rtl/pxu_window.sv
module pxu_window
  import pxu_pkg::*;
(
  input  win_cfg_t        cfg,
  input  logic [XA_W-1:0] addr,
  output logic            hit,
  output logic [XA_W-1:0] xaddr
);
  logic [XA_W:0] span, lim;
  logic [6:0]    shamt;

  always_comb begin
    shamt = {1'b0, cfg.szc} + 7'd1;
    span  = {{XA_W{1'b0}}, 1'b1} << shamt;
    lim   = {1'b0, cfg.base} + span;
    hit   = cfg.en && (addr >= cfg.base) && ({1'b0, addr} < lim);
    xaddr = cfg.xlat + (addr - cfg.base);
  end
endmodule

// File: rtl/pxu_pick.sv
module pxu_pick #(
  parameter int NWIN = 5,
  parameter int IW   = 3,
  parameter int AW   = 64
) (
  input  logic [NWIN-1:0]         hits,
  input  logic [NWIN-1:0][AW-1:0] xa,
  output logic                    hit,
  output logic [AW-1:0]           xaddr,
  output logic [IW-1:0]           idx
);
  // scan downward so the lowest matching index is written last
  always_comb begin
    hit   = 1'b0;
    xaddr = '0;
    idx   = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hits[i]) begin
        hit   = 1'b1;
        xaddr = xa[i];
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pci_xlat_unit.sv
module pci_xlat_unit
  import pxu_pkg::*;
#(
  parameter int NUM_OB = 5,
  parameter int NUM_IB = 3,
  localparam int OB_IW = $clog2(NUM_OB),
  localparam int IB_IW = $clog2(NUM_IB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [8:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [XA_W-1:0]   ob_addr,
  output logic              ob_hit,
  output logic [XA_W-1:0]   ob_xaddr,
  output logic [OB_IW-1:0]  ob_idx,
  input  logic [XA_W-1:0]   ib_addr,
  output logic              ib_hit,
  output logic [XA_W-1:0]   ib_xaddr,
  output logic [IB_IW-1:0]  ib_idx
);
  logic [1:0] rs_q;
  logic       rst_int_n;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  win_cfg_t [NUM_OB-1:0] ob_cfg;
  win_cfg_t [NUM_IB-1:0] ib_cfg;
  logic [31:0] ob_rdata, ib_rdata;

  pxu_bank #(.NWIN(NUM_OB), .INBOUND(1'b0)) u_ob_bank (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(ob_rdata), .cfg(ob_cfg));

  pxu_bank #(.NWIN(NUM_IB), .INBOUND(1'b1)) u_ib_bank (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(ib_rdata), .cfg(ib_cfg));

  // the two banks decode disjoint addresses
  assign reg_rdata = ob_rdata | ib_rdata;

  logic [NUM_OB-1:0]           ob_hits;
  logic [NUM_OB-1:0][XA_W-1:0] ob_xa;
  logic [NUM_IB-1:0]           ib_hits;
  logic [NUM_IB-1:0][XA_W-1:0] ib_xa;

  for (genvar w = 0; w < NUM_OB; w++) begin : g_ob_win
    pxu_window u_win (.cfg(ob_cfg[w]), .addr(ob_addr),
                      .hit(ob_hits[w]), .xaddr(ob_xa[w]));
  end

  for (genvar w = 0; w < NUM_IB; w++) begin : g_ib_win
    pxu_window u_win (.cfg(ib_cfg[w]), .addr(ib_addr),
                      .hit(ib_hits[w]), .xaddr(ib_xa[w]));
  end

  pxu_pick #(.NWIN(NUM_OB), .IW(OB_IW), .AW(XA_W)) u_ob_pick (
    .hits(ob_hits), .xa(ob_xa), .hit(ob_hit), .xaddr(ob_xaddr), .idx(ob_idx));

  pxu_pick #(.NWIN(NUM_IB), .IW(IB_IW), .AW(XA_W)) u_ib_pick (
    .hits(ib_hits), .xa(ib_xa), .hit(ib_hit), .xaddr(ib_xaddr), .idx(ib_idx));
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker #(
  parameter int NUM_OB = 5,
  parameter int NUM_IB = 3,
  localparam int OB_IW = $clog2(NUM_OB),
  localparam int IB_IW = $clog2(NUM_IB)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [8:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             ob_hit,
  input logic [63:0]      ob_xaddr,
  input logic [OB_IW-1:0] ob_idx,
  input logic             ib_hit,
  input logic [63:0]      ib_xaddr,
  input logic [IB_IW-1:0] ib_idx
);
  a_r9_ob_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ob_hit |-> (ob_xaddr == 64'h0 && ob_idx == '0));

  a_r9_ib_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ib_hit |-> (ib_xaddr == 64'h0 && ib_idx == '0));

  a_r8_ob_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    ob_hit |-> (32'(ob_idx) < NUM_OB));

  a_r8_ib_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    ib_hit |-> (32'(ib_idx) < NUM_IB));

  // R4 / R10: an attribute write with the enable clear removes that window at once
  a_r10_ob_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr[8] && reg_addr[4:0] == 5'h10 && !reg_wdata[31])
    |=> !(ob_hit && 3'(ob_idx) == $past(reg_addr[7:5])));

  a_r10_ib_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[8] && !reg_addr[7] && reg_addr[6:5] != 2'b00 &&
     reg_addr[4:0] == 5'h10 && !reg_wdata[31])
    |=> !(ib_hit && 2'(ib_idx) == ($past(reg_addr[6:5]) - 2'd1)));
endmodule

bind pci_xlat_unit pxu_checker #(.NUM_OB(NUM_OB), .NUM_IB(NUM_IB)) u_pxu_checker (.*);

// File: tb/test_pci_xlat_unit.sv
`timescale 1ns/1ps
module test_pci_xlat_unit;
  localparam int NOB = 5;
  localparam int NIB = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [8:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [63:0] ob_addr, ob_xaddr, ib_addr, ib_xaddr;
  logic        ob_hit, ib_hit;
  logic [2:0]  ob_idx;
  logic [1:0]  ib_idx;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  pci_xlat_unit #(.NUM_OB(NOB), .NUM_IB(NIB)) i_pci_xlat_unit (.*);

  // behavioural model: register images per window, slot 0 xlat,1 high page,2 base,3 attr
  logic [31:0] m_ob [NOB][4];
  logic [31:0] m_ib [NIB][4];

  function automatic bit mdl_decode(input logic [8:0] a, output bit grp,
                                    output int w, output int f);
    grp = a[8];
    w = 0; f = 0;
    if (!a[8]) begin
      w = int'(a[7:5]);
      if (w >= NOB) return 0;
      case (a[4:0])
        5'h00: f = 0;
        5'h04: f = 1;
        5'h08: f = 2;
        5'h10: f = 3;
        default: return 0;
      endcase
      return 1;
    end
    if (a[7] || a[6:5] == 2'b00) return 0;
    w = int'(a[6:5]) - 1;
    if (w >= NIB) return 0;
    case (a[4:0])
      5'h00: f = 0;
      5'h0C: f = 1;
      5'h08: f = 2;
      5'h10: f = 3;
      default: return 0;
    endcase
    return 1;
  endfunction

  function automatic logic [31:0] mdl_read(input logic [8:0] a);
    bit g; int w, f;
    if (!mdl_decode(a, g, w, f)) return 32'h0;
    return g ? m_ib[w][f] : m_ob[w][f];
  endfunction

  function automatic void mdl_write(input logic [8:0] a, input logic [31:0] d);
    bit g; int w, f;
    if (!mdl_decode(a, g, w, f)) return;
    if (g) m_ib[w][f] = d;
    else   m_ob[w][f] = d;
  endfunction

  function automatic void mdl_lookup(input bit g, input logic [63:0] a,
                                     output bit hit, output logic [63:0] xa,
                                     output int idx);
    int n;
    logic [31:0] r [4];
    logic [64:0] base, tgt, lim;
    hit = 0; xa = 0; idx = 0;
    n = g ? NIB : NOB;
    for (int w = 0; w < n; w++) begin
      for (int f = 0; f < 4; f++) r[f] = g ? m_ib[w][f] : m_ob[w][f];
      if (g) begin
        base = {1'b0, r[1][19:0], r[2], 12'h0};
        tgt  = {21'h0, r[0], 12'h0};
      end else begin
        base = {21'h0, r[2], 12'h0};
        tgt  = {1'b0, r[1][19:0], r[0], 12'h0};
      end
      lim = base + (65'd1 << (int'(r[3][5:0]) + 1));
      if (r[3][31] && {1'b0, a} >= base && {1'b0, a} < lim) begin
        hit = 1;
        xa  = 64'(tgt + {1'b0, a} - base);
        idx = w;
        return;
      end
    end
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(input string tag, input bit wr, input logic [8:0] ra,
                      input logic [31:0] wd, input logic [63:0] oa,
                      input logic [63:0] ia);
    bit eh; logic [63:0] ex; int ei;
    @(negedge clk);
    reg_wr = wr; reg_addr = ra; reg_wdata = wd; ob_addr = oa; ib_addr = ia;
    #1;
    vectors++;
    check(tag, "reg_rdata", 64'(reg_rdata), 64'(mdl_read(ra)));
    mdl_lookup(1'b0, oa, eh, ex, ei);
    check(tag, "ob_hit", 64'(ob_hit), 64'(eh));
    check(tag, "ob_xaddr", ob_xaddr, ex);
    check(tag, "ob_idx", 64'(ob_idx), 64'(ei));
    mdl_lookup(1'b1, ia, eh, ex, ei);
    check(tag, "ib_hit", 64'(ib_hit), 64'(eh));
    check(tag, "ib_xaddr", ib_xaddr, ex);
    check(tag, "ib_idx", 64'(ib_idx), 64'(ei));
    if (wr) mdl_write(ra, wd);
  endtask

  logic [63:0] cur_oa = 64'h0, cur_ia = 64'h0;

  task automatic wr(input string tag, input logic [8:0] a, input logic [31:0] d);
    step(tag, 1'b1, a, d, cur_oa, cur_ia);
  endtask
  task automatic rd(input string tag, input logic [8:0] a);
    step(tag, 1'b0, a, 32'h0, cur_oa, cur_ia);
  endtask
  task automatic lk(input string tag, input logic [63:0] oa, input logic [63:0] ia);
    cur_oa = oa; cur_ia = ia;
    step(tag, 1'b0, 9'h0, 32'h0, oa, ia);
  endtask

  function automatic logic [8:0] oba(input int w, input logic [4:0] ofs);
    return {1'b0, 3'(w), ofs};
  endfunction
  function automatic logic [8:0] iba(input int w, input logic [4:0] ofs);
    return {2'b10, 2'(w + 1), ofs};
  endfunction

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NOB; w++) for (int f = 0; f < 4; f++) m_ob[w][f] = 32'h0;
    for (int w = 0; w < NIB; w++) for (int f = 0; f < 4; f++) m_ib[w][f] = 32'h0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    ob_addr = '0; ib_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int w = 0; w < NOB; w++) begin
      rd("R1", oba(w, 5'h00)); rd("R1", oba(w, 5'h04));
      rd("R1", oba(w, 5'h08)); rd("R1", oba(w, 5'h10));
    end
    for (int w = 0; w < NIB; w++) begin
      rd("R1", iba(w, 5'h00)); rd("R1", iba(w, 5'h0C)); rd("R1", iba(w, 5'h10));
    end
    lk("R1", 64'h0, 64'h0);
    check("R1", "ob_hit after reset", 64'(ob_hit), 64'h0);
    lk("R1", 64'hC_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);

    // R6: non-identity outbound window, 512 MB at 0xC_0000_0000 -> 0xE000_0000
    wr("R6", oba(0, 5'h00), 32'h000E_0000);
    wr("R6", oba(0, 5'h08), 32'h00C0_0000);
    wr("R6", oba(0, 5'h10), 32'h8000_001C);
    lk("R6", 64'hC_0000_1234, 64'h0);
    check("R6", "ob_xaddr", ob_xaddr, 64'hE000_1234);
    check("R6", "ob_hit", 64'(ob_hit), 64'h1);
    lk("R5", 64'hC_1FFF_FFFF, 64'h0);
    check("R5", "last byte ob_xaddr", ob_xaddr, 64'hFFFF_FFFF);
    lk("R5", 64'hC_2000_0000, 64'h0);
    check("R5", "end miss ob_hit", 64'(ob_hit), 64'h0);
    lk("R5", 64'hB_FFFF_FFFF, 64'h0);

    // R6: high translation page, R2 readback of all 32 bits
    wr("R6", oba(1, 5'h04), 32'hFFF0_0001);
    wr("R6", oba(1, 5'h08), 32'h0010_0000);
    wr("R6", oba(1, 5'h10), 32'h8000_000B);
    rd("R2", oba(1, 5'h04));
    check("R2", "readback", 64'(reg_rdata), 64'hFFF0_0001);
    lk("R6", 64'h1_0000_0010, 64'h0);
    check("R6", "ext ob_xaddr", ob_xaddr, 64'h1000_0000_0010);
    lk("R6", 64'h1_0000_1000, 64'h0);

    // R4: disabled window never matches
    wr("R4", oba(2, 5'h08), 32'h0000_0010);
    wr("R4", oba(2, 5'h10), 32'h0000_0020);
    lk("R4", 64'h0001_0000, 64'h0);
    check("R4", "ob_hit", 64'(ob_hit), 64'h0);

    // R8 / R10: overlapping windows, lowest index wins, then disable and shrink
    wr("R8", oba(3, 5'h00), 32'h0000_0100);
    wr("R8", oba(3, 5'h10), 32'h8000_0028);
    lk("R8", 64'hC_0000_0040, 64'h0);
    check("R8", "ob_idx", 64'(ob_idx), 64'h0);
    wr("R10", oba(0, 5'h10), 32'h0000_001C);
    lk("R10", 64'hC_0000_0040, 64'h0);
    check("R10", "ob_idx", 64'(ob_idx), 64'h3);
    check("R10", "ob_xaddr", ob_xaddr, 64'hC_0010_0040);
    wr("R10", oba(3, 5'h10), 32'h8000_000F);
    lk("R10", 64'hC_0000_0040, 64'h0);
    check("R10", "ob_hit", 64'(ob_hit), 64'h0);
    lk("R10", 64'h0000_FFFF, 64'h0);

    // R7: inbound window with high base page
    wr("R7", iba(0, 5'h0C), 32'h0000_0002);
    wr("R7", iba(0, 5'h08), 32'h0008_0000);
    wr("R7", iba(0, 5'h00), 32'h0000_1000);
    wr("R7", iba(0, 5'h10), 32'h8000_0013);
    lk("R7", 64'h0, 64'h2000_8000_0040);
    check("R7", "ib_xaddr", ib_xaddr, 64'h0100_0040);
    lk("R7", 64'h0, 64'h0000_8000_0040);

    // R5: code 63 covers the whole space; R8 inbound priority
    wr("R5", iba(2, 5'h00), 32'h0000_0001);
    wr("R5", iba(2, 5'h10), 32'h8000_003F);
    lk("R5", 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R5", "ib_idx", 64'(ib_idx), 64'h2);
    check("R5", "ib_xaddr wrap", ib_xaddr, 64'h0FFF);
    lk("R8", 64'h0, 64'h2000_8000_0000);
    check("R8", "ib_idx", 64'(ib_idx), 64'h0);

    // R3: unmapped addresses
    cur_oa = 64'h0000_1000; cur_ia = 64'h0000_0000_0000_0100;
    wr("R3", oba(5, 5'h10), 32'h8000_003F);
    wr("R3", 9'h110, 32'h8000_003F);
    wr("R3", 9'h1F0, 32'h8000_003F);
    wr("R3", oba(0, 5'h14), 32'hDEAD_BEEF);
    wr("R3", iba(0, 5'h04), 32'hDEAD_BEEF);
    wr("R3", oba(4, 5'h0C), 32'hDEAD_BEEF);
    rd("R3", oba(5, 5'h10));
    check("R3", "rdata", 64'(reg_rdata), 64'h0);
    rd("R3", 9'h110); rd("R3", 9'h1F0); rd("R3", oba(0, 5'h14));
    rd("R3", iba(0, 5'h04)); rd("R3", oba(4, 5'h0C));
    lk("R3", 64'hFFFF_0000_0000_0000, 64'h100);

    // R5 / R10: random programming and lookups in a small space
    for (int i = 0; i < 3000; i++) begin
      int sel = int'($urandom_range(0, 9));
      logic [31:0] d;
      if (sel < 4) begin
        int f = int'($urandom_range(0, 3));
        logic [4:0] ofs;
        d = (f == 3) ? {$urandom_range(0, 1) == 1, 25'h0, 6'($urandom_range(10, 17))}
                     : 32'($urandom_range(0, 40));
        if (f == 1) d = 32'($urandom_range(0, 1));
        if ($urandom_range(0, 1) == 1) begin
          ofs = (f == 0) ? 5'h00 : (f == 1) ? 5'h04 : (f == 2) ? 5'h08 : 5'h10;
          wr("R10", oba(int'($urandom_range(0, 7)), ofs), d);
        end else begin
          ofs = (f == 0) ? 5'h00 : (f == 1) ? 5'h0C : (f == 2) ? 5'h08 : 5'h10;
          wr("R10", {2'b10, 2'($urandom_range(0, 3)), ofs}, d);
        end
      end else if (sel < 6) begin
        rd("R2", 9'($urandom_range(0, 511)));
      end else begin
        logic [63:0] hi;
        hi = ($urandom_range(0, 7) == 0) ? 64'h1000_0000_0000 : 64'h0;
        lk("R5", hi | 64'($urandom_range(0, 32'h0008_0000)),
                 hi | 64'($urandom_range(0, 32'h0008_0000)));
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule